// File: doc/BRIEF.md
# Sliding-Window Reuse Stream Buffer

This block sits between a wide memory read stream and an unrolled, pipelined datapath that computes one result per loop iteration from a short window of consecutive array elements. Each input beat carries `LANES` consecutive elements. Each output bundle carries `LANES` complete, overlapping windows of `WIN` elements each, one per datapath lane. Elements shared by neighbouring windows are kept inside the block, so every element crosses the memory interface exactly once. A 100-iteration stream with a window of three needs 102 element reads instead of 300.

The block holds the most recent beat. When the next beat arrives, the held beat and the leading `WIN-1` elements of the new beat form one full group of windows. The held beat is then discarded and the new beat is retained in its place. The first beat of a stream cannot form a full group, so the block emits nothing for it and the lanes always see the same parallelism. The iteration count `n_iter` is captured with the first beat. It fixes how many beats the block accepts, ceil((n_iter+WIN-1)/LANES). It also fixes how many groups the block emits, ceil(n_iter/LANES). If the last group needs no further beat, the block forms that group from the retained beat alone. A per-lane mask marks the real windows in the final group.

Both data sides use valid/ready. A beat transfers on a clock edge where `in_valid` and `in_ready` are both high. A bundle transfers on a clock edge where `out_valid` and `out_ready` are both high. `in_ready` drops whenever the output register holds a bundle that is not being taken in the same cycle. A stalled output therefore pauses memory reads, and no data is lost or duplicated. `n_iter` is a plain control input and must be at least 1 when the first beat of a stream is offered.

Top module: `sw_reuse_buffer`

## Requirements
- R1: In every emitted group with base index j (j = LANES × group number), lane k carries elements j+k+m for m = 0..WIN-1. Element m of lane k sits at bits [(k·WIN+m)·EW +: EW] of `out_win`. Input element e of a beat sits at bits [e·EW +: EW] of `in_data`. Defaults are EW=32, LANES=4 and WIN=3, so the input beat is 128 bits wide.
- R2: Accepting the first beat of a stream produces no output. In the cycle after that beat, `out_valid` is 0.
- R3: A stream of n_iter iterations consumes exactly ceil((n_iter+WIN-1)/LANES) beats, so each element is read once. After the last beat, `in_ready` stays low until the stream's final group has been emitted.
- R4: A stream emits exactly ceil(n_iter/LANES) groups. `out_mask` bit k is 1 exactly when window j+k < n_iter. All groups before the last one have an all-ones mask.
- R5: When the final group needs no element beyond the retained beat, it is emitted without any further input beat.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_win` and `out_mask` hold their values.
- R7: No beat is accepted while an unconsumed bundle sits in the output register. If `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0.
- R8: A synchronous reset (`rst` high at a clock edge) discards retained elements and any pending bundle. After the reset, `out_valid` is 0, `in_ready` is 1, and the next beat starts a new stream.
- R9: After a stream's final group is taken, the block is idle with `in_ready` = 1. It captures a new `n_iter` with the next beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| n_iter | input | CNT_W | Iterations in the stream; captured with the first beat |
| in_valid | input | 1 | Memory beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | LANES·EW | LANES consecutive elements, element 0 in the low bits |
| out_valid | output | 1 | Window bundle valid |
| out_ready | input | 1 | Datapath takes the bundle |
| out_win | output | LANES·WIN·EW | LANES windows of WIN elements each |
| out_mask | output | LANES | Per-lane flag marking a real window |

## Verification
The hardest case to reach is the final group of a stream. Depending on n_iter, it comes either from the last beat or from a flush of the retained beat with no new input. Its mask is only partial for some residues of n_iter modulo LANES. The stimulus table therefore walks iteration counts that cover each residue and both endings, including a stream of a single beat. Some rows also combine gaps on the input with stalls on the output. This shows that a flush waits for a free output slot and that stalled bundles are held. A separate directed test resets the block in the middle of a stream, with a bundle still pending, and then runs a fresh stream.

// File: rtl/sw_reuse_pkg.sv
package sw_reuse_pkg;
  localparam int EW    = 32;
  localparam int LANES = 4;
  localparam int WIN   = 3;
  localparam int CNT_W = 16;
  localparam int EXT   = LANES + WIN - 1;

  function automatic int unsigned beats_for(input int unsigned n, input int unsigned lanes,
                                            input int unsigned win);
    return (n + win - 1 + lanes - 1) / lanes;
  endfunction
endpackage

// File: rtl/sw_window_former.sv
module sw_window_former #(
  parameter int EW    = 32,
  parameter int LANES = 4,
  parameter int WIN   = 3,
  localparam int EXT  = LANES + WIN - 1
) (
  input  logic [LANES*EW-1:0]     held,
  input  logic [(WIN-1)*EW-1:0]   lead,
  output logic [LANES*WIN*EW-1:0] wins
);
  logic [EXT*EW-1:0] ext;
  assign ext = {lead, held};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar m = 0; m < WIN; m++) begin : g_elem
      assign wins[(k*WIN+m)*EW +: EW] = ext[(k+m)*EW +: EW];
    end
  end
endmodule

// File: rtl/sw_stream_ctrl.sv
module sw_stream_ctrl #(
  parameter int LANES = 4,
  parameter int WIN   = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] n_iter,
  input  logic             in_fire,
  input  logic             slot_free,
  output logic             accept_ok,
  output logic             first_beat,
  output logic             emit,
  output logic             from_beat,
  output logic [LANES-1:0] mask
);
  localparam int WIDE = CNT_W + 2;

  logic             started;
  logic             hold_vld;
  logic [CNT_W-1:0] beats_left;
  logic [CNT_W-1:0] win_left;
  logic [CNT_W-1:0] win_take;
  logic [CNT_W-1:0] win_next;
  logic [WIDE-1:0]  beats_total;
  logic             flush;

  assign beats_total = (WIDE'(n_iter) + WIDE'(WIN - 1) + WIDE'(LANES - 1)) / WIDE'(LANES);

  assign accept_ok  = slot_free && (!started || beats_left != '0);
  assign first_beat = in_fire && !started;
  assign flush      = started && hold_vld && beats_left == '0 && win_left != '0 && slot_free;
  assign from_beat  = in_fire && started;
  assign emit       = from_beat || flush;
  assign win_take   = (win_left > CNT_W'(LANES)) ? CNT_W'(LANES) : win_left;
  assign win_next   = win_left - win_take;

  for (genvar k = 0; k < LANES; k++) begin : g_mask
    assign mask[k] = CNT_W'(k) < win_left;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started    <= 1'b0;
      hold_vld   <= 1'b0;
      beats_left <= '0;
      win_left   <= '0;
    end else if (first_beat) begin
      started    <= 1'b1;
      hold_vld   <= 1'b1;
      win_left   <= n_iter;
      beats_left <= CNT_W'(beats_total - WIDE'(1));
    end else if (emit) begin
      win_left <= win_next;
      if (from_beat) beats_left <= beats_left - 1'b1;
      if (win_next == '0) begin
        started  <= 1'b0;
        hold_vld <= 1'b0;
      end
    end
  end

  AST_FLUSH_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
    flush |-> !in_fire);  // R5
endmodule

// File: rtl/sw_reuse_buffer.sv
module sw_reuse_buffer #(
  parameter int EW    = sw_reuse_pkg::EW,
  parameter int LANES = sw_reuse_pkg::LANES,
  parameter int WIN   = sw_reuse_pkg::WIN,
  parameter int CNT_W = sw_reuse_pkg::CNT_W,
  localparam int IN_W  = LANES * EW,
  localparam int OUT_W = LANES * WIN * EW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] n_iter,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_win,
  output logic [LANES-1:0] out_mask
);
  logic                 slot_free, in_fire, first_beat, emit, from_beat;
  logic [LANES-1:0]     grp_mask;
  logic [IN_W-1:0]      held;
  logic [(WIN-1)*EW-1:0] lead;
  logic [OUT_W-1:0]     grp_win;

  assign slot_free = !out_valid || out_ready;
  assign in_fire   = in_valid && in_ready;
  assign lead      = from_beat ? in_data[(WIN-1)*EW-1:0] : '0;

  sw_stream_ctrl #(.LANES(LANES), .WIN(WIN), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .n_iter(n_iter), .in_fire(in_fire), .slot_free(slot_free),
    .accept_ok(in_ready), .first_beat(first_beat), .emit(emit), .from_beat(from_beat),
    .mask(grp_mask)
  );

  sw_window_former #(.EW(EW), .LANES(LANES), .WIN(WIN)) u_form (
    .held(held), .lead(lead), .wins(grp_win)
  );

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else if (in_fire) held <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_win   <= '0;
      out_mask  <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_win   <= grp_win;
      out_mask  <= grp_mask;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_win) && $stable(out_mask));  // R6
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && out_valid |-> out_ready);  // R7
  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_mask != '0 && ((out_mask & (out_mask + 1'b1)) == '0));  // R4
  AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (rst)
    first_beat && !out_valid |=> !out_valid);  // R2
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !out_valid && in_ready);  // R8
endmodule

// File: tb/sw_reuse_buffer_test.sv
`timescale 1ns/1ps
module sw_reuse_buffer_test;
  localparam int EW = 32, LANES = 4, WIN = 3, CNT_W = 16;
  localparam int NV = 9;
  // columns: n_iter, input gap, output gap
  localparam int VEC [NV][3] = '{
    '{8, 0, 0}, '{10, 0, 0}, '{2, 0, 0}, '{5, 1, 0}, '{13, 0, 2},
    '{100, 0, 0}, '{7, 2, 3}, '{4, 0, 1}, '{1, 1, 1}
  };

  logic clk = 0, rst = 1;
  logic [CNT_W-1:0] n_iter = '0;
  logic in_valid = 0, out_ready = 0;
  logic [LANES*EW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [LANES*WIN*EW-1:0] out_win;
  logic [LANES-1:0] out_mask;

  int total = 0, bad = 0, cyc = 0;

  sw_reuse_buffer uut (
    .clk(clk), .rst(rst), .n_iter(n_iter), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_win(out_win), .out_mask(out_mask)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [LANES*EW-1:0] beat_of(input int base, input int b);
    logic [LANES*EW-1:0] d;
    for (int e = 0; e < LANES; e++) d[e*EW +: EW] = EW'(base + b*LANES + e);
    return d;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1; in_valid = 0; out_ready = 0;
    @(negedge clk); rst = 0;
    #1;
    check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
  endtask

  task automatic run_stream(input int n, input int ig, input int og, input int base);
    int nb = (n + WIN - 1 + LANES - 1) / LANES;
    int ng = (n + LANES - 1) / LANES;
    int sent = 0, got = 0, guard = 0, grp_bad = 0;
    bit pend = 0, in_f, out_f, stall_prev = 0, r2_done = 0, r7_bad = 0, r6_bad = 0;
    bit extra_beat = 0;
    logic [LANES*WIN*EW-1:0] pw;
    logic [LANES-1:0] pm;
    while ((got < ng || sent < nb) && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (stall_prev && !(out_valid && out_win == pw && out_mask == pm)) r6_bad = 1;
      if (sent < nb && (pend || (guard % (ig + 1)) == 0)) pend = 1;
      in_valid  = pend;
      in_data   = beat_of(base, sent);
      n_iter    = CNT_W'(n);
      out_ready = (guard % (og + 1)) == 0;
      #1;
      if (out_valid && !out_ready && in_ready) r7_bad = 1;
      in_f  = in_valid && in_ready;
      out_f = out_valid && out_ready;
      stall_prev = out_valid && !out_ready;
      pw = out_win; pm = out_mask;
      if (out_f) begin
        for (int k = 0; k < LANES; k++) begin
          bit real_w = (got*LANES + k) < n;
          if (out_mask[k] != real_w) grp_bad++;
          if (real_w)
            for (int m = 0; m < WIN; m++)
              if (out_win[(k*WIN+m)*EW +: EW] != EW'(base + got*LANES + k + m)) grp_bad++;
        end
        got++;
      end
      @(posedge clk);
      if (in_f) begin sent++; pend = 0; end
      if (in_f && sent == 1 && !r2_done) begin
        #1; r2_done = 1;
        check(out_valid == 1'b0, "R2", "out_valid after first beat", out_valid, 0);
      end
    end
    @(negedge clk); in_valid = 0; out_ready = 1; #1;
    if (in_ready !== 1'b1 || out_valid !== 1'b0) extra_beat = 1;
    check(grp_bad == 0, "R1", "window element/mask mismatches", grp_bad, 0);
    check(got == ng, "R4", "groups emitted", got, ng);
    check(sent == nb, "R3", "beats consumed", sent, nb);
    check(!r6_bad, "R6", "held bundle changed during stall", r6_bad, 0);
    check(!r7_bad, "R7", "in_ready high with pending bundle", r7_bad, 0);
    check(!extra_beat, "R9", "idle after final group", extra_beat, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    do_reset();
    for (int v = 0; v < NV; v++) run_stream(VEC[v][0], VEC[v][1], VEC[v][2], 1000 * (v + 1));

    // R5: a 2-iteration stream needs one beat, then flushes with no input
    @(negedge clk); n_iter = 2; in_valid = 1; in_data = beat_of(50, 0); out_ready = 0;
    @(negedge clk); in_valid = 0;
    @(negedge clk); #1;
    check(out_valid == 1'b1, "R5", "flush group without new beat", out_valid, 1);
    check(out_mask == 4'b0011, "R4", "partial mask", out_mask, 3);
    check(out_win[(1*WIN+2)*EW +: EW] == 32'd53, "R5", "lane1 last element", out_win[(1*WIN+2)*EW +: EW], 53);
    out_ready = 1;
    @(negedge clk); #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9", "idle after flush", {out_valid, in_ready}, 1);
    out_ready = 0;

    // R8: reset mid-stream with a pending bundle
    n_iter = 20; in_valid = 1; in_data = beat_of(70, 0);
    @(negedge clk); in_data = beat_of(70, 1);
    @(negedge clk); in_valid = 0; #1;
    check(out_valid == 1'b1, "R8", "bundle pending before reset", out_valid, 1);
    do_reset();
    run_stream(6, 0, 1, 9000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule